// File: doc/BRIEF.md
# Comma-Based Word Aligner

This block sits right after a deserializer. The deserializer delivers 10-bit parallel words, but it does not know where the real word boundaries are. The aligner keeps the previous word and the current word together as a 20-bit window. It compares all ten 10-bit slices of that window against a programmable alignment pattern. When the pattern is found, the block locks its output boundary to that slice. The realigned words then leave through a registered output stage, two clock edges after the newest word that feeds them.

There are two modes. In pattern mode, the block adopts a newly found boundary, but only while the realign enable is high. With the enable low, the boundary is frozen, and the status output instead flags a pattern seen on some other boundary. In bit-slip mode, the search result never moves the boundary. Each rising edge on the slip request moves the boundary by one bit and wraps after the last offset. A pattern-detect pulse marks every output word that equals the pattern on the boundary in use.

Top module: `word_aligner`

## Requirements
- R1: While rst_n is low, and on the first sample after reset, aligned_word, pat_det and status are 0, and the boundary offset is 0.
- R2: Offset k selects bits [k+9:k] of the window {previous word, current word}, where bit 0 is the LSB of the current word. Offset 0 is the current word itself. aligned_word is updated at the second rising edge after the current word is sampled.
- R3: In pattern mode (slip_mode=0) with realign_en=1, a pattern match on a slice other than the current one moves the offset to that slice. In the same output cycle, aligned_word equals the pattern and pat_det is 1.
- R4: pat_det is 1 for every output word whose selected slice equals the pattern. This includes each repeat on an already locked boundary, and it is 0 otherwise.
- R5: In pattern mode with realign_en=1, status is a lock flag. It is 0 after reset and after any slip, and it becomes 1 with the first pat_det in this mode and stays 1.
- R6: With realign_en=0 in pattern mode, the offset is held. status is 1 exactly for the output words whose window holds the pattern on a slice other than the selected one.
- R7: In bit-slip mode (slip_mode=1), each rising edge of slip_req advances the offset by one, from 9 back to 0. A level held high advances it only once.
- R8: In bit-slip mode, pattern matches never change the offset. status then behaves as in R6.
- R9: If the current slice matches, the offset is kept, even when other slices also match. Otherwise the lowest-numbered matching slice is adopted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raw_word | input | 10 | Unaligned word from the deserializer |
| align_pat | input | 10 | Alignment pattern to search for |
| slip_mode | input | 1 | 0 = pattern mode, 1 = bit-slip mode |
| realign_en | input | 1 | Allows a new boundary to be adopted in pattern mode |
| slip_req | input | 1 | Bit-slip request; acts on its rising edge |
| aligned_word | output | 10 | Realigned output word |
| pat_det | output | 1 | Pattern present on the selected boundary |
| status | output | 1 | Lock flag or re-sync indicator, by mode |

## Verification
The pattern-detect pulse and the re-sync status can both fire in the same output cycle. This happens when one window holds the pattern on the locked slice and also on other slices. The bench provokes this with an alternating 0101… stream and an alternating pattern, with realign disabled. It then expects pat_det and status both high, with the aligned word equal to the pattern. With realign enabled, the same stream checks that the current slice keeps priority over the other matching slices. Once the current slice stops matching, the lowest matching slice is adopted.

// File: rtl/wa_pkg.sv
// Package: shared types for the word aligner.
// Assumes: the mode input is a single bit, 0 selecting pattern search.
package wa_pkg;
    typedef enum logic {
        MODE_PATTERN = 1'b0,
        MODE_SLIP    = 1'b1
    } align_mode_e;
endpackage

// File: rtl/wa_window_search.sv
// Module: holds the previous word and compares every slice of the two-word
// window with the alignment pattern. It registers both the window and the
// per-offset match vector.
// Assumes: slice k is window[k +: WORD_W], with the newest word in the low half.
module wa_window_search #(
    parameter int WORD_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [WORD_W-1:0]   raw_word,
    input  logic [WORD_W-1:0]   align_pat,
    output logic [2*WORD_W-1:0] win_q,
    output logic [WORD_W-1:0]   hit_q
);
    localparam int WIN_W = 2 * WORD_W;

    logic [WORD_W-1:0] prev_q;
    logic [WIN_W-1:0]  window;
    logic [WORD_W-1:0] hit_now;

    // Purpose: form the window from the stored word and the incoming word.
    always_comb begin
        window = {prev_q, raw_word};
    end

    // Purpose: one comparator per bit offset.
    for (genvar k = 0; k < WORD_W; k++) begin : g_cmp
        always_comb begin
            hit_now[k] = (window[k +: WORD_W] == align_pat);
        end
    end

    // Purpose: register the previous word, the window and the match vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            win_q  <= '0;
            hit_q  <= '0;
        end else begin
            prev_q <= raw_word;
            win_q  <= window;
            hit_q  <= hit_now;
        end
    end
endmodule

// File: rtl/wa_offset_ctrl.sv
// Module: chooses the boundary offset for each output word. It handles slip
// edges, adoption of a new boundary, and the lock flag.
// Assumes: hit_q is aligned with the window being output this cycle.
module wa_offset_ctrl
    import wa_pkg::*;
#(
    parameter int WORD_W = 10,
    parameter int OFF_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] hit_q,
    input  align_mode_e       mode,
    input  logic              realign_en,
    input  logic              slip_req,
    output logic [OFF_W-1:0]  off_q,
    output logic [OFF_W-1:0]  off_next,
    output logic              locked_next,
    output logic              adopt_mode
);
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(WORD_W - 1);

    logic             slip_d;
    logic             slip_rise;
    logic             locked_q;
    logic [OFF_W-1:0] lowest_hit;

    // Purpose: detect a rising edge on the slip request.
    always_comb begin
        slip_rise = slip_req & ~slip_d;
    end

    // Purpose: find the lowest-numbered matching offset.
    always_comb begin
        lowest_hit = '0;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            if (hit_q[i]) lowest_hit = OFF_W'(i);
        end
    end

    // Purpose: decide the offset used for this output word.
    always_comb begin
        adopt_mode = (mode == MODE_PATTERN) && realign_en;
        off_next   = off_q;
        if (mode == MODE_SLIP) begin
            if (slip_rise) off_next = (off_q == LAST_OFF) ? '0 : off_q + 1'b1;
        end else if (realign_en && (|hit_q) && !hit_q[off_q]) begin
            off_next = lowest_hit;
        end
    end

    // Purpose: next value of the lock flag.
    always_comb begin
        locked_next = locked_q;
        if (mode == MODE_SLIP && slip_rise) locked_next = 1'b0;
        else if (adopt_mode && hit_q[off_next]) locked_next = 1'b1;
    end

    // Purpose: hold the offset, the slip history and the lock flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q    <= '0;
            slip_d   <= 1'b0;
            locked_q <= 1'b0;
        end else begin
            off_q    <= off_next;
            slip_d   <= slip_req;
            locked_q <= locked_next;
        end
    end
endmodule

// File: rtl/wa_out_stage.sv
// Module: extracts the selected slice and registers the aligned word, the
// pattern-detect pulse and the status flag.
// Assumes: off_next is below WORD_W.
module wa_out_stage #(
    parameter int WORD_W = 10,
    parameter int OFF_W  = $clog2(WORD_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*WORD_W-1:0] win_q,
    input  logic [WORD_W-1:0]   hit_q,
    input  logic [OFF_W-1:0]    off_next,
    input  logic                locked_next,
    input  logic                adopt_mode,
    output logic [WORD_W-1:0]   aligned_word,
    output logic                pat_det,
    output logic                status
);
    logic [WORD_W-1:0] slice;
    logic [WORD_W-1:0] sel_mask;
    logic              other_hit;

    // Purpose: select the slice and build a one-hot mask of the chosen offset.
    always_comb begin
        slice    = '0;
        sel_mask = '0;
        for (int i = 0; i < WORD_W; i++) begin
            if (off_next == OFF_W'(i)) begin
                slice       = win_q[i +: WORD_W];
                sel_mask[i] = 1'b1;
            end
        end
        other_hit = |(hit_q & ~sel_mask);
    end

    // Purpose: register the outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aligned_word <= '0;
            pat_det      <= 1'b0;
            status       <= 1'b0;
        end else begin
            aligned_word <= slice;
            pat_det      <= |(hit_q & sel_mask);
            status       <= adopt_mode ? locked_next : other_hit;
        end
    end
endmodule

// File: rtl/word_aligner.sv
// Module: top of the word aligner. Search stage, offset control and
// output stage. The latency is two edges from the newest word.
// Assumes: raw_word carries bits MSB-first in time, one word per clock.
module word_aligner
    import wa_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] raw_word,
    input  logic [WORD_W-1:0] align_pat,
    input  logic              slip_mode,
    input  logic              realign_en,
    input  logic              slip_req,
    output logic [WORD_W-1:0] aligned_word,
    output logic              pat_det,
    output logic              status
);
    localparam int OFF_W = $clog2(WORD_W);
    localparam int WIN_W = 2 * WORD_W;

    logic [WIN_W-1:0]  win_q;
    logic [WORD_W-1:0] hit_q;
    logic [OFF_W-1:0]  cur_off;
    logic [OFF_W-1:0]  off_next;
    logic              locked_next;
    logic              adopt_mode;
    align_mode_e       mode;

    // Purpose: map the mode pin onto the enumerated type.
    always_comb begin
        mode = align_mode_e'(slip_mode);
    end

    wa_window_search #(.WORD_W(WORD_W)) u_search (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw_word  (raw_word),
        .align_pat (align_pat),
        .win_q     (win_q),
        .hit_q     (hit_q)
    );

    wa_offset_ctrl #(.WORD_W(WORD_W), .OFF_W(OFF_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit_q       (hit_q),
        .mode        (mode),
        .realign_en  (realign_en),
        .slip_req    (slip_req),
        .off_q       (cur_off),
        .off_next    (off_next),
        .locked_next (locked_next),
        .adopt_mode  (adopt_mode)
    );

    wa_out_stage #(.WORD_W(WORD_W), .OFF_W(OFF_W)) u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .win_q        (win_q),
        .hit_q        (hit_q),
        .off_next     (off_next),
        .locked_next  (locked_next),
        .adopt_mode   (adopt_mode),
        .aligned_word (aligned_word),
        .pat_det      (pat_det),
        .status       (status)
    );
endmodule

// File: rtl/wa_checker.sv
// Module: assertion checker bound to word_aligner.
// Assumes: slip_req is held low during reset.
module wa_checker #(
    parameter int WORD_W = 10,
    parameter int OFF_W  = $clog2(WORD_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] align_pat,
    input logic              slip_mode,
    input logic              realign_en,
    input logic              slip_req,
    input logic [WORD_W-1:0] aligned_word,
    input logic              pat_det,
    input logic              status,
    input logic [OFF_W-1:0]  cur_off
);
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(WORD_W - 1);

    AST_OFF_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cur_off <= LAST_OFF); // R2

    AST_SLIP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (slip_mode && $rose(slip_req)) |=>
        (cur_off == (($past(cur_off) == LAST_OFF) ? '0 : $past(cur_off) + 1'b1))); // R7

    AST_SLIP_NO_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
        (slip_mode && !$rose(slip_req)) |=> (cur_off == $past(cur_off))); // R8

    AST_HOLD_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (!slip_mode && !realign_en) |=> (cur_off == $past(cur_off))); // R6

    AST_DET_IS_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        pat_det |-> (aligned_word == $past(align_pat, 2))); // R4

    AST_DET_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!slip_mode && realign_en) && pat_det) |-> status); // R5
endmodule

bind word_aligner wa_checker #(.WORD_W(WORD_W)) u_wa_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .align_pat    (align_pat),
    .slip_mode    (slip_mode),
    .realign_en   (realign_en),
    .slip_req     (slip_req),
    .aligned_word (aligned_word),
    .pat_det      (pat_det),
    .status       (status),
    .cur_off      (cur_off)
);

// File: tb/word_aligner_tb.sv
// Bench: directed scenarios for word_aligner, each task checks its results.
module word_aligner_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] raw_word = '0;
    logic [9:0] align_pat = 10'h0FA;
    logic       slip_mode = 1'b0;
    logic       realign_en = 1'b1;
    logic       slip_req = 1'b0;
    logic [9:0] aligned_word;
    logic       pat_det;
    logic       status;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [9:0] PAT = 10'h0FA;

    always #2 clk = ~clk;

    word_aligner u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .raw_word     (raw_word),
        .align_pat    (align_pat),
        .slip_mode    (slip_mode),
        .realign_en   (realign_en),
        .slip_req     (slip_req),
        .aligned_word (aligned_word),
        .pat_det      (pat_det),
        .status       (status)
    );

    function automatic logic [9:0] ext(input logic [19:0] w, input int k);
        return w[k +: 10];
    endfunction

    task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [9:0] w);
        raw_word = w;
        @(negedge clk);
    endtask

    // Place a 20-bit window on the input, then one filler; outputs are ready after it.
    task automatic send_win(input logic [19:0] w, input logic [9:0] fill);
        send(w[19:10]);
        send(w[9:0]);
        send(fill);
    endtask

    task automatic pulse_slip();
        slip_req = 1'b1;
        @(negedge clk);
        slip_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 word", aligned_word, 10'h000);
        chk("R1 det", {9'b0, pat_det}, 10'h000);
        chk("R1 status", {9'b0, status}, 10'h000);
        send_win(20'h3C1A7, 10'h000);
        chk("R1 offset0", aligned_word, 10'h1A7);
    endtask

    task automatic t_passthrough();
        send(10'h3C1);
        send(10'h2A7);
        send(10'h111);
        chk("R2 latency", aligned_word, 10'h2A7);
        send(10'h000);
        chk("R2 next", aligned_word, 10'h111);
        chk("R5 unlocked", {9'b0, status}, 10'h000);
    endtask

    task automatic t_acquire();
        logic [19:0] w = {6'b0, PAT, 4'b0};
        send(10'h000);
        send_win(w, 10'h000);
        chk("R3 word", aligned_word, PAT);
        chk("R3 det", {9'b0, pat_det}, 10'h001);
        chk("R5 locked", {9'b0, status}, 10'h001);
        send(10'h000);
        chk("R3 held offset4", aligned_word, ext({w[9:0], 10'h000}, 4));
        chk("R4 no det", {9'b0, pat_det}, 10'h000);
        chk("R5 sticky", {9'b0, status}, 10'h001);
        send_win(w, 10'h000);
        chk("R4 repeat det", {9'b0, pat_det}, 10'h001);
    endtask

    task automatic t_hold();
        logic [19:0] w = {3'b0, PAT, 7'b0};
        realign_en = 1'b0;
        send(10'h000);
        send_win(w, 10'h000);
        chk("R6 held word", aligned_word, ext(w, 4));
        chk("R6 no det", {9'b0, pat_det}, 10'h000);
        chk("R6 resync", {9'b0, status}, 10'h001);
        send(10'h000);
        chk("R6 resync clears", {9'b0, status}, 10'h000);
        realign_en = 1'b1;
        send_win(w, 10'h000);
        chk("R3 adopt7", aligned_word, PAT);
        chk("R3 det7", {9'b0, pat_det}, 10'h001);
    endtask

    task automatic t_slip();
        logic [19:0] w  = 20'hA5C3F;
        logic [19:0] wp = {5'b0, PAT, 5'b0};
        slip_mode = 1'b1;
        pulse_slip();
        pulse_slip();
        pulse_slip();
        send_win(w, 10'h000);
        chk("R7 wrap to 0", aligned_word, ext(w, 0));
        slip_req = 1'b1;
        repeat (4) @(negedge clk);
        slip_req = 1'b0;
        send_win(w, 10'h000);
        chk("R7 single step", aligned_word, ext(w, 1));
        send(10'h000);
        send_win(wp, 10'h000);
        chk("R8 ignore word", aligned_word, ext(wp, 1));
        chk("R8 no det", {9'b0, pat_det}, 10'h000);
        chk("R8 resync", {9'b0, status}, 10'h001);
        slip_mode = 1'b0;
        realign_en = 1'b1;
        send(10'h000);
        send_win(w, 10'h000);
        chk("R5 slip clears lock", {9'b0, status}, 10'h000);
    endtask

    task automatic t_collide();
        realign_en = 1'b0;
        align_pat = 10'h2AA;
        send(10'h155);
        send(10'h155);
        send(10'h155);
        chk("R4 det on lock", {9'b0, pat_det}, 10'h001);
        chk("R6 resync same cycle", {9'b0, status}, 10'h001);
        chk("R6 word", aligned_word, 10'h2AA);
        realign_en = 1'b1;
        align_pat = 10'h155;
        send(10'h155);
        send(10'h155);
        send(10'h155);
        chk("R9 lowest adopt", aligned_word, 10'h155);
        chk("R9 det", {9'b0, pat_det}, 10'h001);
        send_win(20'h3C5A9, 10'h155);
        chk("R9 offset0", aligned_word, ext(20'h3C5A9, 0));
        send(10'h155);
        send(10'h155);
        send(10'h155);
        send_win(20'h3C5A9, 10'h155);
        chk("R9 current kept", aligned_word, ext(20'h3C5A9, 0));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_passthrough();
        t_acquire();
        t_hold();
        t_slip();
        t_collide();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule